// File: doc/BRIEF.md
# Prescaled 16-bit Event Timer

This block is a 16-bit up-counter that a host processor reaches through four byte-wide registers. Each count step comes from one of two sources: an internal tick that fires on every fourth system clock, or rising edges on an external clock pin. The external pin goes either through a two-flop synchronizer or straight to the edge detector. A prescaler passes every 1st, 2nd, 4th or 8th source tick on to the counter. A run bit gates counting. Rolling over from 0xFFFF sets a sticky overflow flag, which also drives the interrupt output. A special-event trigger input forces the count to zero.

A wide-access bit couples the two count bytes through a one-byte buffer, so the host can read or write all 16 bits as one consistent value. A read of the low byte captures the live high byte into the buffer. A write of the high byte fills only the buffer, and the next write of the low byte loads both bytes into the counter at once.

The host interface is a plain register bus. Write strobes take effect at the clock edge. Read data is combinational from the address. There is no stream traffic, so no valid/ready handshake and no back-pressure.

Register map (`bus_addr`):
- 0: count low byte.
- 1: count high byte, or the buffer when wide access is on.
- 2: control, with bit 0 run, bit 1 external source, bit 2 unsynchronized external path, bits 4:3 prescale code and bit 5 wide access. Bits 7:6 read as zero.
- 3: overflow flag in bit 0.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count, the control register, the flag and `ovf_irq` are all 0, and every register reads 0.
- R2: With control bit 1 = 0 and prescale code 0, a running counter advances once every 4 system clocks.
- R3: Prescale code (control bits 4:3) 0, 1, 2 and 3 divide the source tick rate by 1, 2, 4 and 8.
- R4: With control bit 1 = 1 and bit 2 = 0, the counter advances once per rising edge of `ext_clk`, seen through the two-flop synchronizer.
- R5: With control bit 1 = 1 and bit 2 = 1, the counter also advances once per rising edge of `ext_clk`, seen without the synchronizer.
- R6: With control bit 0 = 0, the count holds its value.
- R7: A step from 0xFFFF to 0x0000 sets the flag (register 3 bit 0, and `ovf_irq`). The flag stays set until the host writes 0 to it. An overflow in the same cycle as that write leaves the flag set.
- R8: A high `evt_clr` makes the count 0 on the next clock. It takes priority over a register write and over an increment.
- R9: With control bit 5 = 0, a write to register 0 or 1 replaces only that byte of the count, and each register reads back its own live byte.
- R10: With control bit 5 = 1, a read of register 0 copies the live high byte into the buffer. A later read of register 1 returns that copy.
- R11: With control bit 5 = 1, a write to register 1 leaves the count unchanged. A following write to register 0 loads {buffer, data} into the count and clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ext_clk | input | 1 | External count input |
| evt_clr | input | 1 | Special-event trigger, clears the count |
| ovf_irq | output | 1 | Overflow flag |

## Verification
Most faults inside the block show up as a wrong count read back after a known number of ticks. A wrong prescaler mask, a wrong divider or a lost external edge each change the count within one prescale period, and the error grows with every tick after that. A fault in the wide-access buffer shows on the very next read of register 1, as a stale or live high byte where the other was expected. A fault in the flag logic shows on `ovf_irq` one clock after the rollover, or after the host clears the flag.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
  localparam int BUS_W = 8;

  localparam logic [1:0] ADDR_CNT_LO = 2'd0;
  localparam logic [1:0] ADDR_CNT_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_FLAG   = 2'd3;

  // Control register, bit 0 at the bottom.
  typedef struct packed {
    logic       wide;     // bit 5: buffered 16-bit access
    logic [1:0] ps;       // bits 4:3: prescale code
    logic       raw;      // bit 2: external input bypasses synchronizer
    logic       ext;      // bit 1: external source select
    logic       run;      // bit 0: count enable
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/evt_timer16_tick.sv
module evt_timer16_tick #(
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic raw_sel,
  input  logic ext_in,
  output logic tick
);
  logic int_tick;

  generate
    if (DIV_W == 0) begin : g_nodiv
      assign int_tick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
      end
      assign int_tick = &div_q;
    end
  endgenerate

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_last_q;
  logic                   raw_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= '0;
      sync_last_q <= 1'b0;
      raw_last_q  <= 1'b0;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], ext_in};
      sync_last_q <= sync_q[SYNC_STAGES-1];
      raw_last_q  <= ext_in;
    end
  end

  logic edge_sync, edge_raw;
  assign edge_sync = sync_q[SYNC_STAGES-1] & ~sync_last_q;
  assign edge_raw  = ext_in & ~raw_last_q;

  assign tick = ext_sel ? (raw_sel ? edge_raw : edge_sync) : int_tick;
endmodule

// File: rtl/evt_timer16_psc.sv
module evt_timer16_psc #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  input  logic [PS_W-1:0] sel,
  output logic            pulse
);
  localparam int PCNT_W = (1 << PS_W) - 1;

  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] mask;

  assign mask  = ~({PCNT_W{1'b1}} << sel);
  assign pulse = en && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pcnt_q <= '0;
    else if (clr) pcnt_q <= '0;
    else if (en)  pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/evt_timer16_core.sv
module evt_timer16_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign ovf = inc && !clr && !ld && (&cnt);
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ext_clk,
  input  logic             evt_clr,
  output logic             ovf_irq
);
  localparam int CNT_W = 2 * BUS_W;

  ctrl_t            ctrl_q;
  logic             flag_q;
  logic [BUS_W-1:0] hbuf_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ld_val;
  logic             src_tick, cnt_inc, ovf_pulse, cnt_ld;
  logic             wr_lo, wr_hi, wr_ctrl, flag_wr, rd_lo;

  assign wr_lo   = bus_wr && (bus_addr == ADDR_CNT_LO);
  assign wr_hi   = bus_wr && (bus_addr == ADDR_CNT_HI);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign flag_wr = bus_wr && (bus_addr == ADDR_FLAG);
  assign rd_lo   = bus_rd && (bus_addr == ADDR_CNT_LO);

  assign cnt_ld = wr_lo || (wr_hi && !ctrl_q.wide);

  always_comb begin
    if (ctrl_q.wide)  ld_val = {hbuf_q, bus_wdata};
    else if (wr_lo)   ld_val = {cnt_q[CNT_W-1:BUS_W], bus_wdata};
    else              ld_val = {bus_wdata, cnt_q[BUS_W-1:0]};
  end

  evt_timer16_tick #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_sel (ctrl_q.ext),
    .raw_sel (ctrl_q.raw),
    .ext_in  (ext_clk),
    .tick    (src_tick)
  );

  evt_timer16_psc #(.PS_W(2)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (src_tick && ctrl_q.run),
    .clr   (evt_clr || cnt_ld),
    .sel   (ctrl_q.ps),
    .pulse (cnt_inc)
  );

  evt_timer16_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (evt_clr),
    .ld     (cnt_ld),
    .ld_val (ld_val),
    .inc    (cnt_inc),
    .cnt    (cnt_q),
    .ovf    (ovf_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      hbuf_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (ovf_pulse)    flag_q <= 1'b1;
      else if (flag_wr) flag_q <= bus_wdata[0];
      if (ctrl_q.wide && wr_hi)      hbuf_q <= bus_wdata;
      else if (ctrl_q.wide && rd_lo) hbuf_q <= cnt_q[CNT_W-1:BUS_W];
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CNT_LO: bus_rdata = cnt_q[BUS_W-1:0];
      ADDR_CNT_HI: bus_rdata = ctrl_q.wide ? hbuf_q : cnt_q[CNT_W-1:BUS_W];
      ADDR_CTRL:   bus_rdata = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
      default:     bus_rdata = {{(BUS_W-1){1'b0}}, flag_q};
    endcase
  end

  assign ovf_irq = flag_q;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_clr,
  input logic             cnt_ld,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             flag,
  input logic             flag_wr,
  input logic             wdata0,
  input logic             run,
  input logic             wide,
  input logic             rd_lo,
  input logic [CNT_W/2-1:0] hbuf
);
  a_r8_evt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> (cnt == '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !evt_clr && !cnt_ld) |=> $stable(cnt));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_clr && !cnt_ld) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);

  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !wdata0 && !ovf) |=> !flag);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_wr) |=> flag);

  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && rd_lo) |=> (hbuf == $past(cnt[CNT_W-1:CNT_W/2])));
endmodule

bind evt_timer16 evt_timer16_chk #(.CNT_W(16)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_clr (evt_clr),
  .cnt_ld  (cnt_ld),
  .cnt     (cnt_q),
  .ovf     (ovf_pulse),
  .flag    (flag_q),
  .flag_wr (flag_wr),
  .wdata0  (bus_wdata[0]),
  .run     (ctrl_q.run),
  .wide    (ctrl_q.wide),
  .rd_lo   (rd_lo),
  .hbuf    (hbuf_q)
);

// File: tb/evt_timer16_tb.sv
`timescale 1ns/1ps
module evt_timer16_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_clk = 1'b0;
  logic       evt_clr = 1'b0;
  logic       ovf_irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  evt_timer16 u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .evt_clr(evt_clr), .ovf_irq(ovf_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input int exp);
    n_checks++;
    if (act < exp - 1 || act > exp + 1) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d +/-1", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ext_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic set_count8(input logic [15:0] v);
    wr(2'd2, 8'h00);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 reset register", d, 0);
    end
    check("R1 reset ovf_irq", ovf_irq, 0);
  endtask

  task automatic t_prescale();
    logic [7:0] d;
    for (int ps = 0; ps < 4; ps++) begin
      set_count8(16'h0000);
      wr(2'd2, {3'b000, ps[1:0], 3'b001});
      repeat (256) @(negedge clk);
      wr(2'd2, 8'h00);
      rd(2'd0, d);
      check_near(ps == 0 ? "R2 internal tick rate" : "R3 prescale ratio",
                 d, 64 >> ps);
    end
  endtask

  task automatic t_hold();
    logic [7:0] d;
    set_count8(16'h0042);
    repeat (100) @(negedge clk);
    rd(2'd0, d);
    check("R6 hold when stopped", d, 8'h42);
  endtask

  task automatic t_ext(input bit raw);
    logic [7:0] d;
    set_count8(16'h0000);
    wr(2'd2, {5'b00000, raw, 2'b11});
    ext_edges(10);
    rd(2'd0, d);
    check(raw ? "R5 unsynchronized edges" : "R4 synchronized edges", d, 10);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    set_count8(16'hFFFF);
    wr(2'd2, 8'h01);
    repeat (12) @(negedge clk);
    check("R7 flag set on rollover", ovf_irq, 1);
    rd(2'd0, d);
    check("R7 count wrapped small", (d < 8'd6) ? 1 : 0, 1);
    repeat (20) @(negedge clk);
    check("R7 flag sticky", ovf_irq, 1);
    wr(2'd3, 8'h00);
    #1 check("R7 flag cleared by write", ovf_irq, 0);
    // same-cycle overflow and clear: unsynchronized edge at 0xFFFF
    set_count8(16'hFFFF);
    wr(2'd2, 8'h07);
    @(negedge clk);
    ext_clk = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R7 overflow wins over clear", ovf_irq, 1);
    repeat (3) @(negedge clk);
    ext_clk = 1'b0;
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_evt();
    logic [7:0] d;
    set_count8(16'h1234);
    @(negedge clk); evt_clr = 1'b1;
    @(negedge clk); evt_clr = 1'b0;
    rd(2'd0, d); check("R8 clear low", d, 0);
    rd(2'd1, d); check("R8 clear high", d, 0);
    set_count8(16'h5555);
    @(negedge clk);
    evt_clr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h99; bus_wr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0; bus_wr = 1'b0;
    rd(2'd0, d); check("R8 clear beats write", d, 0);
  endtask

  task automatic t_bytes8();
    logic [7:0] d;
    set_count8(16'h0000);
    wr(2'd1, 8'hA5);
    rd(2'd0, d); check("R9 low untouched by high write", d, 8'h00);
    wr(2'd0, 8'h3C);
    rd(2'd1, d); check("R9 high readback", d, 8'hA5);
    rd(2'd0, d); check("R9 low readback", d, 8'h3C);
  endtask

  task automatic t_wide();
    logic [7:0] d;
    set_count8(16'h3456);
    wr(2'd2, 8'h20);
    wr(2'd1, 8'h12);
    rd(2'd0, d); check("R11 low unchanged after high write", d, 8'h56);
    rd(2'd1, d); check("R11 high unchanged after high write", d, 8'h34);
    wr(2'd1, 8'h12);
    wr(2'd0, 8'h78);
    rd(2'd0, d); check("R11 atomic load low", d, 8'h78);
    rd(2'd1, d); check("R11 atomic load high", d, 8'h12);
    // capture while running
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hF0);
    wr(2'd2, 8'h21);
    rd(2'd0, d);
    repeat (200) @(negedge clk);
    rd(2'd1, d); check("R10 high from capture", d, 8'h00);
    rd(2'd0, d);
    rd(2'd1, d); check("R10 fresh capture", d, 8'h01);
    // prescaler cleared by low write, divide by 8 on raw edges
    wr(2'd2, 8'h3F);
    ext_edges(5);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    ext_edges(7);
    rd(2'd0, d); check("R11 prescaler cleared", d, 0);
    ext_edges(1);
    rd(2'd0, d); check("R11 eighth edge counts", d, 1);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_hold();
    t_ext(1'b0);
    t_ext(1'b1);
    t_overflow();
    t_evt();
    t_bytes8();
    t_wide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule